// File: doc/BRIEF.md
# Programmable Interval Counter Channel

One down-counting timer channel with six counting modes. A slow count-enable strobe (`tick_i`) paces it, not the system clock. A controlling bus block programs a mode code and a BCD flag through a write strobe. It then supplies an initial count through a load strobe. The channel produces a mode-dependent output waveform on `out_o` and shows its current count on `count_o`, so that the bus block can latch or read it.

The gate input acts differently by mode. In modes 0 and 4 it is a level enable that pauses counting. In modes 1 and 5 its rising edge is the trigger that starts or restarts a count. In modes 2 and 3 its rising edge restarts the period, and a low level pauses it. After reset the channel is idle until a mode is programmed. The gate edge detector resets to a parameterised level, so a gate held at that level from reset produces no edge.

The BCD flag is only stored and reported. Counting is always binary. When one cycle carries more than one event, they are handled in this order: mode write, then load, then gate rising edge, then tick.

Top module: `interval_counter_chan`

## Requirements
- R1: After reset, until the first mode write, `idle_o`=1, `out_o`=0 and `count_o`=0. Loads, ticks and gate edges in this state have no effect.
- R2: Mode codes 6 and 7 behave as modes 2 and 3, and `mode_o` reports the effective code (6→2, 7→3). `bcd_o` reports the BCD flag given with the last mode write.
- R3: In the cycle after a mode write, `out_o` is 0 if the mode is 0 and 1 for any other mode.
- R4: A load value of 0 stands for 65536 ticks.
- R5: Mode 0: a load sets `count_o` to the value and drives `out_o` low. Each enabled tick decrements the count. `out_o` rises on the tick that takes the count to 0 and then stays high while the count wraps to 0xFFFF and keeps decrementing.
- R6: In modes 0 and 4 a low gate holds the count. A gate rising edge does not restart the count.
- R7: Mode 1: a load sets the count and `out_o`=1 but does not start counting, and a gate that stays high from reset gives no trigger. Each gate rising edge reloads the count and drives `out_o` low. `out_o` returns high after that many ticks.
- R8: Mode 2: `count_o` runs N, N-1, …, 1, then shows N again at the period end. `out_o` is low for exactly the one tick interval that begins at each period end, and never at the start.
- R9: Mode 3: at tick phase p of a period of N ticks, `out_o` is high while p < (N+1)/2 and low for the remaining phases. `count_o` shows N − (2p mod N).
- R10: Mode 4: `out_o` is 1 after load. It goes low for one tick interval on the tick that takes the count to 0 and does not pulse again when the count wraps.
- R11: Mode 5: the same strobe as mode 4, except that counting starts only on a gate rising edge after a load.
- R12: In modes 2 and 3 a gate rising edge restarts the period from phase 0, and a low gate pauses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count-enable strobe, one per counter clock |
| gate_i | input | 1 | Gate level |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_i | input | 3 | Raw mode code (0 to 7) |
| bcd_i | input | 1 | BCD flag written with the mode |
| load_i | input | 1 | Initial count load strobe |
| load_val_i | input | CW | Initial count (0 means 2^CW) |
| count_o | output | CW | Current visible count |
| out_o | output | 1 | Channel output waveform |
| mode_o | output | 3 | Effective mode (0 to 5) |
| bcd_o | output | 1 | Stored BCD flag |
| idle_o | output | 1 | No mode programmed since reset |

## Verification
The hardest case to reach is the load of 0. It can only be seen at its terminal event, 65536 enabled ticks after the load, and until then the count looks like an ordinary wrapping value. The bench holds `tick_i` high for a long run to reach the count of 1, then checks that `out_o` rises only on the following tick. Gate triggering in modes 1 and 5 is also hard to reach because a gate that is already high gives no edge. The stimulus therefore drives the gate low and then high again, each in its own cycle, to produce a clean rising edge.

// File: rtl/ict_pkg.sv
package ict_pkg;
  typedef enum logic [2:0] {
    ICT_TERM    = 3'd0,
    ICT_ONESHOT = 3'd1,
    ICT_RATE    = 3'd2,
    ICT_SQUARE  = 3'd3,
    ICT_SWSTB   = 3'd4,
    ICT_HWSTB   = 3'd5
  } ict_mode_e;

  // codes 6/7 fold onto 2/3
  function automatic ict_mode_e ict_norm(input logic [2:0] raw);
    if (raw[2:1] == 2'b11) return ict_mode_e'({1'b0, raw[1:0]});
    return ict_mode_e'(raw);
  endfunction

  function automatic logic ict_is_per(input ict_mode_e m);
    return (m == ICT_RATE) || (m == ICT_SQUARE);
  endfunction

  function automatic logic ict_is_trig(input ict_mode_e m);
    return (m == ICT_ONESHOT) || (m == ICT_HWSTB);
  endfunction
endpackage

// File: rtl/ict_gate_edge.sv
module ict_gate_edge #(
  parameter logic RST_LVL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  output logic rise_o
);
  logic gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= RST_LVL;
    else         gate_q <= gate_i;
  end

  assign rise_o = gate_i & ~gate_q;
endmodule

// File: rtl/ict_ctrl.sv
module ict_ctrl
  import ict_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  logic [2:0] raw_i,
  input  logic      bcd_i,
  output ict_mode_e mode_o,
  output logic      bcd_o,
  output logic      valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o  <= ICT_TERM;
      bcd_o   <= 1'b0;
      valid_o <= 1'b0;
    end else if (wr_i) begin
      mode_o  <= ict_norm(raw_i);
      bcd_o   <= bcd_i;
      valid_o <= 1'b1;
    end
  end

  p_alias_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && raw_i[2:1] == 2'b11) |=> (mode_o == {2'b01, $past(raw_i[0])}));
endmodule

// File: rtl/ict_view.sv
module ict_view
  import ict_pkg::*;
#(
  parameter int CW = 16,
  localparam int IW = CW + 1
) (
  input  ict_mode_e         mode_i,
  input  logic              valid_i,
  input  logic [IW-1:0]     cnt_i,
  input  logic [IW-1:0]     init_i,
  output logic [CW-1:0]     count_o
);
  logic [IW:0]   dbl;
  logic [IW-1:0] red;

  always_comb begin
    dbl = {cnt_i, 1'b0};
    red = IW'((dbl >= {1'b0, init_i}) ? dbl - {1'b0, init_i} : dbl);
    if (!valid_i)                  count_o = '0;
    else if (mode_i == ICT_RATE)   count_o = CW'(init_i - cnt_i);
    else if (mode_i == ICT_SQUARE) count_o = CW'(init_i - red);
    else                           count_o = cnt_i[CW-1:0];
  end
endmodule

// File: rtl/interval_counter_chan.sv
module interval_counter_chan
  import ict_pkg::*;
#(
  parameter int   CW           = 16,
  parameter logic GATE_RST_LVL = 1'b1,
  localparam int  IW           = CW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          gate_i,
  input  logic          mode_wr_i,
  input  logic [2:0]    mode_i,
  input  logic          bcd_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] count_o,
  output logic          out_o,
  output logic [2:0]    mode_o,
  output logic          bcd_o,
  output logic          idle_o
);
  ict_mode_e     mode_q;
  logic          valid_q, rise;
  logic          loaded_q, run_q, done_q, out_q;
  logic [IW-1:0] cnt_q, init_q;

  ict_ctrl u_ctrl (
    .clk_i, .rst_ni, .wr_i(mode_wr_i), .raw_i(mode_i), .bcd_i,
    .mode_o(mode_q), .bcd_o, .valid_o(valid_q)
  );

  ict_gate_edge #(.RST_LVL(GATE_RST_LVL)) u_gate (
    .clk_i, .rst_ni, .gate_i, .rise_o(rise)
  );

  ict_view #(.CW(CW)) u_view (
    .mode_i(mode_q), .valid_i(valid_q), .cnt_i(cnt_q), .init_i(init_q), .count_o
  );

  logic          per, trig, en, te, wrap;
  logic [IW-1:0] ph_inc, ph_nxt, half, nval;
  ict_mode_e     wr_mode;

  always_comb begin
    wr_mode = ict_norm(mode_i);
    per     = ict_is_per(mode_q);
    trig    = ict_is_trig(mode_q);
    en      = tick_i && run_q && (trig || gate_i);
    te      = en && !per && !done_q && (cnt_q[CW-1:0] == CW'(1));
    ph_inc  = cnt_q + IW'(1);
    wrap    = (ph_inc == init_q);
    ph_nxt  = wrap ? '0 : ph_inc;
    half    = IW'(({1'b0, init_q} + (IW+1)'(1)) >> 1);
    nval    = {(load_val_i == '0), load_val_i};  // 0 -> 2^CW
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loaded_q <= 1'b0;
      run_q    <= 1'b0;
      done_q   <= 1'b0;
      out_q    <= 1'b0;
      cnt_q    <= '0;
      init_q   <= '0;
    end else if (mode_wr_i) begin
      loaded_q <= 1'b0;
      run_q    <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
      init_q   <= '0;
      out_q    <= (wr_mode != ICT_TERM);
    end else if (!valid_q) begin
      // idle until programmed
    end else if (load_i) begin
      init_q   <= nval;
      loaded_q <= 1'b1;
      done_q   <= 1'b0;
      if (per) begin
        cnt_q <= '0;
        run_q <= 1'b1;
        out_q <= 1'b1;
      end else begin
        cnt_q <= {1'b0, load_val_i};
        run_q <= !trig;
        out_q <= (mode_q != ICT_TERM);
      end
    end else if (rise && loaded_q && (trig || per)) begin
      run_q  <= 1'b1;
      done_q <= 1'b0;
      cnt_q  <= per ? '0 : {1'b0, init_q[CW-1:0]};
      out_q  <= (mode_q != ICT_ONESHOT);
    end else if (tick_i) begin
      if (per) begin
        if (en) cnt_q <= ph_nxt;
        if (mode_q == ICT_RATE) out_q <= !(en && wrap);
        else if (en)            out_q <= (ph_nxt < half);
      end else begin
        if (en) cnt_q <= {1'b0, CW'(cnt_q[CW-1:0] - CW'(1))};
        if (te) done_q <= 1'b1;
        case (mode_q)
          ICT_TERM, ICT_ONESHOT: if (te) out_q <= 1'b1;
          default:               out_q <= !te;
        endcase
      end
    end
  end

  assign out_o  = out_q;
  assign mode_o = mode_q;
  assign idle_o = !valid_q;

  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> (!out_o && count_o == '0));

  p_prog_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_wr_i && mode_i == 3'd0) |=> !out_o);

  p_prog_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_wr_i && mode_i != 3'd0) |=> out_o);

  p_m0_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && mode_o == 3'd0 && out_o && !load_i && !mode_wr_i) |=> out_o);

  p_pause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && (mode_o == 3'd0 || mode_o == 3'd4) && !gate_i && !load_i && !mode_wr_i)
      |=> $stable(count_o));

  p_strobe_once_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && mode_o == 3'd4 && !out_o && tick_i && !load_i && !mode_wr_i) |=> out_o);
endmodule

// File: tb/interval_counter_chan_tb_top.sv
module interval_counter_chan_tb_top;
  localparam int CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, gate = 1, mode_wr = 0, bcd = 0, load = 0;
  logic [2:0] mode = '0;
  logic [CW-1:0] load_val = '0;
  logic [CW-1:0] count;
  logic out, bcd_q, idle;
  logic [2:0] mode_q;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  interval_counter_chan #(.CW(CW), .GATE_RST_LVL(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .gate_i(gate),
    .mode_wr_i(mode_wr), .mode_i(mode), .bcd_i(bcd), .load_i(load),
    .load_val_i(load_val), .count_o(count), .out_o(out), .mode_o(mode_q),
    .bcd_o(bcd_q), .idle_o(idle)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic prog(input logic [2:0] m, input logic b);
    @(negedge clk); mode = m; bcd = b; mode_wr = 1;
    @(negedge clk); mode_wr = 0;
  endtask

  task automatic ld(input logic [CW-1:0] v);
    @(negedge clk); load_val = v; load = 1;
    @(negedge clk); load = 0;
  endtask

  task automatic tk(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic set_gate(input logic v);
    @(negedge clk); gate = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", "idle", idle, 1); chk("R1", "out", out, 0); chk("R1", "count", count, 0);
    ld(16'd5); tk(3); set_gate(0); set_gate(1);
    chk("R1", "count after stimulus", count, 0); chk("R1", "out after stimulus", out, 0);
    chk("R1", "still idle", idle, 1);
  endtask

  task automatic t_alias;
    prog(3'd6, 0);
    chk("R2", "mode 6 alias", mode_q, 2); chk("R3", "out after prog 6", out, 1);
    ld(16'd3); chk("R2", "count after load", count, 3);
    tk(3); chk("R2", "mode6 period pulse", out, 0); chk("R2", "mode6 reload", count, 3);
    prog(3'd7, 1);
    chk("R2", "mode 7 alias", mode_q, 3); chk("R2", "bcd stored", bcd_q, 1);
    chk("R3", "out after prog 7", out, 1);
    prog(3'd0, 0);
    chk("R3", "out after prog 0", out, 0); chk("R2", "bcd cleared", bcd_q, 0);
  endtask

  task automatic t_mode0;
    prog(3'd0, 0); ld(16'd4);
    chk("R5", "load count", count, 4); chk("R5", "load out", out, 0);
    tk(3); chk("R5", "count 1", count, 1); chk("R5", "out before end", out, 0);
    tk(1); chk("R5", "count 0", count, 0); chk("R5", "out at end", out, 1);
    tk(1); chk("R5", "wrap", count, 16'hFFFF); chk("R5", "out sticky", out, 1);
  endtask

  task automatic t_zero;
    prog(3'd0, 0); ld(16'd0);
    tk(1); chk("R4", "first tick wraps", count, 16'hFFFF); chk("R4", "out low", out, 0);
    tk(65534); chk("R4", "count 1", count, 1); chk("R4", "out still low", out, 0);
    tk(1); chk("R4", "terminal after 65536", out, 1); chk("R4", "count 0", count, 0);
  endtask

  task automatic t_pause;
    prog(3'd0, 0); ld(16'd10); tk(2);
    chk("R6", "counted", count, 8);
    set_gate(0); tk(3); chk("R6", "held while gate low", count, 8);
    set_gate(1); chk("R6", "no restart on rise", count, 8);
    tk(1); chk("R6", "resumes", count, 7);
  endtask

  task automatic t_mode1;
    prog(3'd1, 0); ld(16'd3); tk(2);
    chk("R7", "no start on load", count, 3); chk("R7", "out high", out, 1);
    set_gate(0); set_gate(1);
    chk("R7", "trigger out low", out, 0); chk("R7", "trigger count", count, 3);
    tk(2); chk("R7", "counting", count, 1); chk("R7", "still low", out, 0);
    tk(1); chk("R7", "out high at end", out, 1);
    set_gate(0); set_gate(1);
    chk("R7", "retrigger count", count, 3); chk("R7", "retrigger out", out, 0);
    tk(1); chk("R7", "retrigger counts", count, 2);
  endtask

  task automatic t_mode2;
    prog(3'd2, 0); ld(16'd3);
    chk("R8", "start count", count, 3); chk("R8", "start out", out, 1);
    tk(1); chk("R8", "p1 count", count, 2); chk("R8", "p1 out", out, 1);
    tk(1); chk("R8", "p2 count", count, 1); chk("R8", "p2 out", out, 1);
    tk(1); chk("R8", "end count", count, 3); chk("R8", "end pulse", out, 0);
    tk(1); chk("R8", "next count", count, 2); chk("R8", "pulse one tick", out, 1);
  endtask

  task automatic t_mode3;
    int exp_c[5] = '{5, 3, 1, 4, 2};
    int exp_o[5] = '{1, 1, 1, 0, 0};
    prog(3'd3, 0); ld(16'd5);
    for (int p = 0; p < 5; p++) begin
      chk("R9", $sformatf("N5 count p%0d", p), count, exp_c[p]);
      chk("R9", $sformatf("N5 out p%0d", p), out, exp_o[p]);
      tk(1);
    end
    chk("R9", "N5 wrap count", count, 5); chk("R9", "N5 wrap out", out, 1);
    ld(16'd4);
    tk(1); chk("R9", "N4 p1 out", out, 1);
    tk(1); chk("R9", "N4 p2 out", out, 0); chk("R9", "N4 p2 count", count, 4);
    tk(1); chk("R9", "N4 p3 out", out, 0);
    tk(1); chk("R9", "N4 p0 out", out, 1);
  endtask

  task automatic t_mode4;
    prog(3'd4, 0); ld(16'd2);
    chk("R10", "out after load", out, 1);
    tk(1); chk("R10", "count 1", count, 1); chk("R10", "out high", out, 1);
    tk(1); chk("R10", "strobe", out, 0); chk("R10", "count 0", count, 0);
    tk(1); chk("R10", "strobe ends", out, 1); chk("R10", "wraps", count, 16'hFFFF);
  endtask

  task automatic t_mode5;
    prog(3'd5, 0); ld(16'd2); tk(1);
    chk("R11", "waits for gate", count, 2); chk("R11", "out high", out, 1);
    set_gate(0); set_gate(1);
    tk(1); chk("R11", "count 1", count, 1); chk("R11", "out high", out, 1);
    tk(1); chk("R11", "strobe", out, 0);
    tk(1); chk("R11", "strobe ends", out, 1);
  endtask

  task automatic t_per_gate;
    prog(3'd2, 0); ld(16'd4); tk(2);
    chk("R12", "counted", count, 2);
    set_gate(0); tk(2); chk("R12", "paused", count, 2);
    set_gate(1); chk("R12", "restart", count, 4);
    tk(1); chk("R12", "runs after restart", count, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_alias; t_mode0; t_pause; t_mode1; t_mode2;
    t_mode3; t_mode4; t_mode5; t_per_gate; t_zero;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule